// File: doc/BRIEF.md
# Shared Pin Function Router

This block decides which of several candidate functions owns each of two shared package pins, and routes values and directions to match. The first pin carries a general control output by default. When the configuration enables it, the pin carries address bit 2 instead. The second pin can carry one of four functions:

- a control output
- an interrupt input from an external synthesizer
- a CD-ROM chip-select output
- a volume-down button input

A fixed precedence picks one of these four. The electrical pad cell sits outside the block. The router supplies the pad output value and the output enable. For an input function, it returns the synchronized pad level to the function that owns the pin.

The synthesizer interrupt depends on a strap: a pull-down on the I/O-write pin. The block reads that pin once, on the first clock edge after reset is released. The result holds until the next reset. Configuration bits may change at any time, and pin ownership follows them in the same cycle.

Top module: `shared_pin_router`

## Requirements
- R1: Pin A always drives (`padAOe` = 1). It outputs `addr2Out` when `cfgAddr2En` = 1, and `ctl0Out` otherwise.
- R2: When `cfgVolEn` = 1, pin B belongs to the volume-down input, whatever the other settings. `padBOe` = 0, `padBOut` = 0, `synthIrqIn` = 0 and `volDownIn` carries the synchronized pad level.
- R3: When `cfgVolEn` = 0 and `cfgCdSelEn` = 1, pin B drives `cdSelOut` with `padBOe` = 1, whatever the strap.
- R4: When `cfgVolEn` = 0, `cfgCdSelEn` = 0 and a pull-down strap was captured, pin B is the synthesizer interrupt input. `padBOe` = 0, `padBOut` = 0, `volDownIn` = 0 and `synthIrqIn` carries the synchronized pad level.
- R5: When no other function owns pin B, pin B drives `ctl1Out` with `padBOe` = 1.
- R6: The strap is read on the first rising clock edge with `rstN` high. A low level on `strapIowLevel` means a pull-down is present. Later changes of `strapIowLevel` have no effect until the next reset.
- R7: `padBIn` passes through two flops. An input function that owns the pin sees the level `padBIn` had two rising edges earlier. A routed input whose function does not own the pin reads 0.
- R8: While `rstN` is low:
  - the synchronizer holds 0;
  - the strap counts as not present;
  - `volDownIn` and `synthIrqIn` read 0 unless the volume function owns the pin, and even then they read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgAddr2En | input | 1 | Pin A carries address bit 2 |
| cfgVolEn | input | 1 | Volume-control enable; highest priority on pin B |
| cfgCdSelEn | input | 1 | CD-ROM chip-select enable |
| strapIowLevel | input | 1 | Level of the I/O-write pin; low means pull-down strap |
| ctl0Out | input | 1 | Control output 0 value |
| addr2Out | input | 1 | Address bit 2 value |
| ctl1Out | input | 1 | Control output 1 value |
| cdSelOut | input | 1 | CD-ROM chip-select value |
| padBIn | input | 1 | Level read back from pin B |
| padAOut | output | 1 | Pin A output value |
| padAOe | output | 1 | Pin A output enable |
| padBOut | output | 1 | Pin B output value |
| padBOe | output | 1 | Pin B output enable |
| volDownIn | output | 1 | Synchronized volume-down level, 0 when not owner |
| synthIrqIn | output | 1 | Synchronized synthesizer interrupt level, 0 when not owner |

## Verification
The bench randomizes configuration, function values and pad level on every cycle. It then sets up three reset releases, so the strap is captured once low, once high and once low again.

After each capture, the strap input keeps toggling at random. A design that re-reads the strap after reset release would flip pin B between interrupt input and control output, and the comparison on `padBOe` would catch it.

Every setting with volume enabled also sets chip-select and the strap at random. A wrong precedence would therefore drive the pin while the volume function owns it. A synchronizer one stage short, or one that leaks the pad level to a function that does not own the pin, shows up as a mismatch against the two-deep reference queue.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

  typedef enum logic [1:0] {
    OWN_CTL1  = 2'd0,
    OWN_IRQ   = 2'd1,
    OWN_CDSEL = 2'd2,
    OWN_VOLDN = 2'd3
  } ownerB_e;

  typedef struct packed {
    logic selAddr2;
    logic bDrive;
    logic bSrcCd;
    logic bToVol;
    logic bToIrq;
  } pinStrobes_t;

endpackage

// File: rtl/pinmux_ctrl.sv
module pinmux_ctrl
  import pinmux_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgAddr2En,
  input  logic        cfgVolEn,
  input  logic        cfgCdSelEn,
  input  logic        strapIowLevel,
  output pinStrobes_t strobes
);

  logic    strapDone;
  logic    strapPd;
  ownerB_e ownerB;

  // single capture after reset release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapDone <= 1'b0;
      strapPd   <= 1'b0;
    end else if (!strapDone) begin
      strapDone <= 1'b1;
      strapPd   <= ~strapIowLevel;
    end
  end

  // fixed precedence for pin B
  always_comb begin
    if (cfgVolEn)        ownerB = OWN_VOLDN;
    else if (cfgCdSelEn) ownerB = OWN_CDSEL;
    else if (strapPd)    ownerB = OWN_IRQ;
    else                 ownerB = OWN_CTL1;
  end

  always_comb begin
    strobes.selAddr2 = cfgAddr2En;
    strobes.bDrive   = (ownerB == OWN_CDSEL) || (ownerB == OWN_CTL1);
    strobes.bSrcCd   = (ownerB == OWN_CDSEL);
    strobes.bToVol   = (ownerB == OWN_VOLDN);
    strobes.bToIrq   = (ownerB == OWN_IRQ);
  end

  // R6
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strapDone) |-> $stable(strapPd));

  // R2
  vol_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.bToVol |-> !strobes.bDrive && !strobes.bToIrq);

endmodule

// File: rtl/pinmux_path.sv
module pinmux_path
  import pinmux_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  pinStrobes_t strobes,
  input  logic        ctl0Out,
  input  logic        addr2Out,
  input  logic        ctl1Out,
  input  logic        cdSelOut,
  input  logic        padBIn,
  output logic        padAOut,
  output logic        padAOe,
  output logic        padBOut,
  output logic        padBOe,
  output logic        volDownIn,
  output logic        synthIrqIn
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= 1'b0;
    else       syncQ[0] <= padBIn;
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[i] <= 1'b0;
      else       syncQ[i] <= syncQ[i-1];
    end
  end

  always_comb begin
    padAOe     = 1'b1;
    padAOut    = strobes.selAddr2 ? addr2Out : ctl0Out;
    padBOe     = strobes.bDrive;
    padBOut    = strobes.bDrive ? (strobes.bSrcCd ? cdSelOut : ctl1Out) : 1'b0;
    volDownIn  = strobes.bToVol & syncQ[LAST];
    synthIrqIn = strobes.bToIrq & syncQ[LAST];
  end

  // R1
  pin_a_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.selAddr2 |-> padAOut == addr2Out);

  // R2
  vol_input_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.bToVol |-> !padBOe && !padBOut);

  // R3
  cd_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.bSrcCd |-> padBOe && padBOut == cdSelOut);

  // R7
  sync_depth_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.bToVol |-> volDownIn == $past(syncQ[LAST-1]));

endmodule

// File: rtl/shared_pin_router.sv
module shared_pin_router
  import pinmux_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgAddr2En,
  input  logic cfgVolEn,
  input  logic cfgCdSelEn,
  input  logic strapIowLevel,
  input  logic ctl0Out,
  input  logic addr2Out,
  input  logic ctl1Out,
  input  logic cdSelOut,
  input  logic padBIn,
  output logic padAOut,
  output logic padAOe,
  output logic padBOut,
  output logic padBOe,
  output logic volDownIn,
  output logic synthIrqIn
);

  pinStrobes_t strobes;

  pinmux_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .cfgAddr2En    (cfgAddr2En),
    .cfgVolEn      (cfgVolEn),
    .cfgCdSelEn    (cfgCdSelEn),
    .strapIowLevel (strapIowLevel),
    .strobes       (strobes)
  );

  pinmux_path #(.SYNC_STAGES(SYNC_STAGES)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .ctl0Out    (ctl0Out),
    .addr2Out   (addr2Out),
    .ctl1Out    (ctl1Out),
    .cdSelOut   (cdSelOut),
    .padBIn     (padBIn),
    .padAOut    (padAOut),
    .padAOe     (padAOe),
    .padBOut    (padBOut),
    .padBOe     (padBOe),
    .volDownIn  (volDownIn),
    .synthIrqIn (synthIrqIn)
  );

endmodule

// File: tb/shared_pin_router_test.sv
module shared_pin_router_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgAddr2En = 0, cfgVolEn = 0, cfgCdSelEn = 0, strapIowLevel = 1;
  logic ctl0Out = 0, addr2Out = 0, ctl1Out = 0, cdSelOut = 0, padBIn = 0;
  logic padAOut, padAOe, padBOut, padBOe, volDownIn, synthIrqIn;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  bit mDone = 0, mPd = 0;
  bit q0 = 0, q1 = 0;

  always #4 clk = ~clk;

  shared_pin_router uut (
    .clk(clk), .rstN(rstN), .cfgAddr2En(cfgAddr2En), .cfgVolEn(cfgVolEn),
    .cfgCdSelEn(cfgCdSelEn), .strapIowLevel(strapIowLevel), .ctl0Out(ctl0Out),
    .addr2Out(addr2Out), .ctl1Out(ctl1Out), .cdSelOut(cdSelOut), .padBIn(padBIn),
    .padAOut(padAOut), .padAOe(padAOe), .padBOut(padBOut), .padBOe(padBOe),
    .volDownIn(volDownIn), .synthIrqIn(synthIrqIn)
  );

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mDone = 0; mPd = 0; q0 = 0; q1 = 0;
    end else begin
      q1 = q0;
      q0 = padBIn;
      if (!mDone) begin
        mDone = 1;
        mPd = !strapIowLevel;
      end
    end
  end

  task automatic checkNow();
    int owner;  // 3 vol, 2 cd, 1 irq, 0 ctl1
    string tagB;
    if (cfgVolEn) owner = 3;
    else if (cfgCdSelEn) owner = 2;
    else if (mPd) owner = 1;
    else owner = 0;
    case (owner)
      3: tagB = "R2";
      2: tagB = "R3";
      1: tagB = "R4";
      default: tagB = "R5";
    endcase
    if (!rstN) tagB = "R8";
    chk("R1", "padAOe", padAOe, 1'b1);
    chk("R1", "padAOut", padAOut, cfgAddr2En ? addr2Out : ctl0Out);
    chk(tagB, "padBOe", padBOe, owner == 2 || owner == 0);
    chk(tagB, "padBOut", padBOut, owner == 2 ? cdSelOut : (owner == 0 ? ctl1Out : 1'b0));
    chk(rstN ? "R7" : "R8", "volDownIn", volDownIn, owner == 3 ? q1 : 1'b0);
    chk(rstN ? "R7" : "R8", "synthIrqIn", synthIrqIn, owner == 1 ? q1 : 1'b0);
    if (rstN && mDone && !cfgVolEn && !cfgCdSelEn)
      chk("R6", "strap ownership", padBOe, !mPd);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      checkNow();
      rstN = !((cyc % 1000) < 4);
      cfgAddr2En = 1'($urandom);
      cfgVolEn   = ($urandom % 4) == 0;
      cfgCdSelEn = ($urandom % 3) == 0;
      ctl0Out    = 1'($urandom);
      addr2Out   = 1'($urandom);
      ctl1Out    = 1'($urandom);
      cdSelOut   = 1'($urandom);
      padBIn     = 1'($urandom);
      // level seen at the first edge after release: low, high, low
      if ((cyc % 1000) == 4) strapIowLevel = ((cyc / 1000) == 1);
      else strapIowLevel = 1'($urandom);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule